// File: doc/BRIEF.md
# Pin Change Interrupt Detector

This block watches four input pins for a level that differs from a stored copy of those pins. The copy is taken each time software reads or writes the monitored port. When any pin that is configured as an input differs from its stored copy and the feature is enabled, a sticky change flag is set. The flag, gated by an interrupt enable, drives a request line. That line can serve as an interrupt or as a wake-up request for a sleep controller.

Software clears the condition in two steps. First it accesses the port, which refreshes the copy and ends the difference. Then it pulses the clear strobe. A clear that comes while a difference still exists has no lasting effect, because the set condition keeps winning.

The flag is held by a two-state machine. FLAG_IDLE moves to FLAG_HELD on the *detect* transition, which happens when the set condition is true. FLAG_HELD returns to FLAG_IDLE on the *acknowledge* transition, which happens when the clear strobe is high and the set condition is false. In every other case each state holds. All registers reset synchronously, and while reset is low the stored copy tracks the pins.

Top module: `ioc_detector`

## Requirements
- R1: While `rst_n` is low, the flag clears and the stored copy loads the current pin levels. After release with unchanged pins and the feature enabled, the flag stays 0.
- R2: With `ioc_en_i`=1, an input pin whose level differs from its stored copy sets `flag_o` at the next rising clock edge.
- R3: A pin whose `dir_in_i` bit is 0 (output) is excluded from the comparison. A `dir_in_i` bit of 1 marks an input.
- R4: A difference on any single input pin is enough to set the flag, because the per-pin results are ORed.
- R5: Once set, the flag stays set while `flag_clr_i` is low, even after the pins return to their stored values.
- R6: A clear strobe applied while a difference persists leaves `flag_o` at 1.
- R7: A `port_acc_i` pulse loads the pins into the stored copy at that clock edge. After that, a clear strobe with no difference drops the flag at the next edge.
- R8: With `ioc_en_i`=0 the flag is never set, but `port_acc_i` still refreshes the stored copy.
- R9: When the set condition and `flag_clr_i` occur in the same cycle, the flag is set or stays set.
- R10: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Synchronized pin levels |
| dir_in_i | input | 4 | Per-pin direction, 1 = input (monitored) |
| port_acc_i | input | 1 | Port read or write strobe; refreshes the stored copy |
| ioc_en_i | input | 1 | Change-detect enable |
| flag_clr_i | input | 1 | Flag clear strobe |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Interrupt / wake-up request |

## Verification
Two functions can fall in the same cycle: detection (or a persisting difference) and the clear strobe. A port access can also coincide with a difference. The bench provokes both by holding a pin away from its stored value while pulsing `flag_clr_i`, both alone and together with `port_acc_i`. In each case it expects the flag to remain 1 after the edge. A clear issued one cycle after the access is expected to drop the flag.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
    typedef enum logic [0:0] {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;
endpackage

// File: rtl/ioc_snapshot.sv
module ioc_snapshot #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    input  logic         port_acc_i,
    output logic [N-1:0] snap_o
);
    // Copy follows the pins during reset and on every port access.
    always_ff @(posedge clk) begin
        if (!rst_n || port_acc_i) begin
            snap_o <= pin_i;
        end
    end
endmodule

// File: rtl/ioc_mismatch.sv
module ioc_mismatch #(
    parameter int N = 4
) (
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] snap_i,
    input  logic [N-1:0] dir_in_i,
    input  logic         en_i,
    output logic         set_o
);
    logic [N-1:0] diff;

    for (genvar g = 0; g < N; g++) begin : g_pin
        // Only input-direction pins take part.
        assign diff[g] = (pin_i[g] ^ snap_i[g]) & dir_in_i[g];
    end

    assign set_o = en_i & (|diff);
endmodule

// File: rtl/ioc_flag_fsm.sv
module ioc_flag_fsm
    import ioc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i)           state_d = FLAG_HELD; // detect
            FLAG_HELD: if (clr_i && !set_i) state_d = FLAG_IDLE; // acknowledge
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLAG_HELD);
    end
endmodule

// File: rtl/ioc_detector.sv
module ioc_detector #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] dir_in_i,
    input  logic         port_acc_i,
    input  logic         ioc_en_i,
    input  logic         flag_clr_i,
    input  logic         irq_en_i,
    output logic         flag_o,
    output logic         irq_o
);
    logic [N-1:0] snap;
    logic         set_req;

    ioc_snapshot #(.N(N)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .port_acc_i(port_acc_i),
        .snap_o    (snap)
    );

    ioc_mismatch #(.N(N)) u_cmp (
        .pin_i   (pin_i),
        .snap_i  (snap),
        .dir_in_i(dir_in_i),
        .en_i    (ioc_en_i),
        .set_o   (set_req)
    );

    ioc_flag_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_req),
        .clr_i (flag_clr_i),
        .flag_o(flag_o)
    );

    assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/ioc_detector_chk.sv
module ioc_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic ioc_en_i,
    input logic flag_clr_i,
    input logic irq_en_i,
    input logic flag_o,
    input logic irq_o,
    input logic set_req
);
    // R1: reset clears the flag
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !flag_o);

    // R5: sticky without clear
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !flag_clr_i |=> flag_o);

    // R6 / R9: set condition wins over clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag_o);

    // R7: clear with no difference drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i && !set_req |=> !flag_o);

    // R8: disabled feature never raises the flag
    p_no_rise_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ioc_en_i |=> !$rose(flag_o));

    // R10: request gated by enable and flag
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);
    p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);
endmodule

bind ioc_detector ioc_detector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ioc_en_i  (ioc_en_i),
    .flag_clr_i(flag_clr_i),
    .irq_en_i  (irq_en_i),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .set_req   (set_req)
);

// File: tb/ioc_detector_tb.sv
module ioc_detector_tb;
    localparam int N = 4;
    localparam int NV = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic [N-1:0] dir = '1;
    logic         acc = 1'b0;
    logic         en = 1'b0;
    logic         clr = 1'b0;
    logic         ie = 1'b0;
    logic         flag, irq;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    ioc_detector #(.N(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .dir_in_i  (dir),
        .port_acc_i(acc),
        .ioc_en_i  (en),
        .flag_clr_i(clr),
        .irq_en_i  (ie),
        .flag_o    (flag),
        .irq_o     (irq)
    );

    // {pin, dir, acc, en, clr, ie, exp_flag, exp_irq}; copy starts at 0000
    localparam logic [13:0] VEC [NV] = '{
        14'b0000_1111_0_1_0_1_0_0, // R1 no difference, no flag
        14'b0001_1111_0_1_0_1_1_1, // R2 pin0 changes -> flag, R10 irq
        14'b0000_1111_0_1_0_0_1_0, // R5 sticky after revert, R10 irq gated off
        14'b0000_1111_0_1_1_1_0_0, // R7 clear with no difference
        14'b0100_1011_0_1_0_1_0_0, // R3 pin2 is output: masked
        14'b0100_1111_0_1_0_1_1_1, // R4 single pin2 difference sets
        14'b0100_1111_0_1_1_1_1_1, // R6 clear while difference persists
        14'b0100_1111_1_1_0_1_1_1, // R7 access refreshes copy to 0100
        14'b0100_1111_0_1_1_1_0_0, // R7 clear now succeeds
        14'b1100_1111_0_0_0_1_0_0, // R8 disabled: no flag
        14'b1100_1111_1_0_0_1_0_0, // R8 access while disabled -> copy 1100
        14'b1100_1111_0_1_0_1_0_0, // R8 copy was refreshed: no flag
        14'b1000_1111_0_1_1_1_1_1, // R9 set and clear together: set wins
        14'b1000_1111_1_1_1_1_1_1, // R9 access+clear with difference: set wins
        14'b1000_1111_0_1_1_1_0_0  // R7 clear after refresh
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic f, input logic i,
                         input logic ef, input logic ei);
        checks++;
        if (f !== ef || i !== ei) begin
            fails++;
            $display("FAIL %s flag/irq actual=%b%b expected=%b%b", req, f, i, ef, ei);
        end
    endtask

    initial begin : watchdog
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // Reset with pins at 0000
        rst_n = 1'b0; pin = 4'b0000; dir = 4'b1111; en = 1'b1; ie = 1'b1;
        tick(); tick();
        check("R1", flag, irq, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            {pin, dir, acc, en, clr, ie} = VEC[k][13:2];
            tick();
            check($sformatf("R%0d-vec%0d", 0, k), flag, irq, VEC[k][1], VEC[k][0]);
        end
        acc = 1'b0; clr = 1'b0;

        // R1: reset while flagged, with pins at 1010 loaded into the copy
        pin = 4'b0101; tick(); // difference vs 1000 -> flag set
        check("R2", flag, irq, 1'b1, 1'b1);
        rst_n = 1'b0; pin = 4'b1010;
        tick();
        check("R1", flag, irq, 1'b0, 1'b0);
        tick();
        rst_n = 1'b1;
        tick(); tick();
        check("R1", flag, irq, 1'b0, 1'b0);

        // R3: change on output pin only, then flip it to input
        dir = 4'b1110; pin = 4'b1011;
        tick();
        check("R3", flag, irq, 1'b0, 1'b0);
        dir = 4'b1111;
        tick();
        check("R4", flag, irq, 1'b1, 1'b1);

        // R10: irq follows enable while flag held
        ie = 1'b0; #1;
        check("R10", flag, irq, 1'b1, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule